// File: doc/BRIEF.md
# SHA-512 Two-Round Compression Unit

This unit advances a SHA-512 working state by two compression rounds in a single operation. The eight 64-bit working words are carried in two 256-bit vectors. The primary vector holds A, B, E and F. The secondary vector holds C, D, G and H. A 128-bit input carries the two already-summed message-plus-constant words, one for each round. The result is the new A, B, E and F, packed in the same lane layout as the primary input.

Because the output uses the primary input's layout, the caller chains operations with a simple swap. The primary vector it just supplied becomes the next secondary vector, and the result becomes the next primary vector. Two chained operations therefore cover four rounds.

Inputs are taken on a clock edge where the input strobe is high. Both rounds are evaluated as one combinational path, and the result is held in a register until the next accepted operation. Message expansion, round-constant storage and final digest addition belong to the surrounding datapath.

Top module: `sha512_dual_round`

## Requirements
- R1: The upper-case sigma-0 function of a word is the XOR of three right rotations of it, by 28, 34 and 39 bit positions.
- R2: The upper-case sigma-1 function of a word is the XOR of three right rotations of it, by 14, 18 and 41 bit positions.
- R3: The majority of (x,y,z) is (x&y)^(x&z)^(y&z). The choice of (e,f,g) is (e&f)^(~e&g).
- R4: Input lane layout, where lane k is bits [64k+63:64k]. In `abef_in`, lane 3 is A, lane 2 is B, lane 1 is E and lane 0 is F. In `cdgh_in`, lane 3 is C, lane 2 is D, lane 1 is G and lane 0 is H.
- R5: The first round consumes `wk_in` lane 0 (bits 63:0). The second round consumes `wk_in` lane 1 (bits 127:64).
- R6: Each round forms a temporary t = choice(E,F,G) + sigma1(E) + wk + H. The new A is t + majority(A,B,C) + sigma0(A). The new E is t + D. Every addition wraps modulo 2^64.
- R7: In each round the other words move down one place. B, C and D take the old A, B and C. F, G and H take the old E, F and G.
- R8: After both rounds, `abef_out` holds A in lane 3, B in lane 2, E in lane 1 and F in lane 0.
- R9: `out_valid` is high exactly in the cycle after an edge that sampled `in_valid` high. In that cycle `abef_out` holds the result for the inputs sampled at that edge.
- R10: When `in_valid` is low at an edge, `abef_out` keeps its value and `out_valid` is low afterwards, whatever the other inputs carry.
- R11: A synchronous active-high `rst` clears `out_valid` and `abef_out` to zero.
- R12: Feeding each result back as the primary input, with the previous primary vector as the secondary input, gives the same state as running SHA-512 rounds back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are sampled on this edge |
| abef_in | input | 256 | Working words A, B, E, F |
| cdgh_in | input | 256 | Working words C, D, G, H |
| wk_in | input | 128 | Two message-plus-constant sums, round 1 in lane 0 |
| out_valid | output | 1 | Result register was loaded on the previous edge |
| abef_out | output | 256 | Updated A, B, E, F after two rounds |

## Verification
Every result is due one clock after the edge that samples its operands, because a single register lies between the inputs and `abef_out`. The bench drives operands on the falling edge and waits for the next rising edge. It then samples one time unit later, when both `out_valid` and the new result are settled.

The hold and reset checks use the same timing. Operands change with the strobe low, or reset is raised, and the outputs are read just after the following rising edge. The chained test compares the state after each pair of operations with a word-array model that runs the rounds one at a time.

// File: rtl/sha512_dr_pkg.sv
package sha512_dr_pkg;

    localparam int WORD_W  = 64;
    localparam int LANES   = 4;
    localparam int VEC_W   = WORD_W * LANES;
    localparam int ROUNDS  = 2;
    localparam int WK_W    = WORD_W * ROUNDS;

    // lane positions inside the two state vectors (R4, R8)
    localparam int LANE_A = 3;
    localparam int LANE_B = 2;
    localparam int LANE_E = 1;
    localparam int LANE_F = 0;
    localparam int LANE_C = 3;
    localparam int LANE_D = 2;
    localparam int LANE_G = 1;
    localparam int LANE_H = 0;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [VEC_W-1:0]  vec_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t e;
        word_t f;
        word_t g;
        word_t h;
    } wstate_t;

    function automatic word_t rotr(input word_t x, input int n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    // R1
    function automatic word_t big_sig0(input word_t x);
        return rotr(x, 28) ^ rotr(x, 34) ^ rotr(x, 39);
    endfunction

    // R2
    function automatic word_t big_sig1(input word_t x);
        return rotr(x, 14) ^ rotr(x, 18) ^ rotr(x, 41);
    endfunction

    // R3
    function automatic word_t fn_maj(input word_t x, input word_t y, input word_t z);
        return (x & y) ^ (x & z) ^ (y & z);
    endfunction

    function automatic word_t fn_ch(input word_t e, input word_t f, input word_t g);
        return (e & f) ^ (~e & g);
    endfunction

    function automatic word_t lane_get(input vec_t v, input int idx);
        return v[idx*WORD_W +: WORD_W];
    endfunction

endpackage

// File: rtl/sha512_dr_unpack.sv
module sha512_dr_unpack
    import sha512_dr_pkg::*;
(
    input  vec_t    abef_i,
    input  vec_t    cdgh_i,
    output wstate_t st_o
);
    // R4: lane mapping into the working words
    always_comb begin
        st_o.a = lane_get(abef_i, LANE_A);
        st_o.b = lane_get(abef_i, LANE_B);
        st_o.e = lane_get(abef_i, LANE_E);
        st_o.f = lane_get(abef_i, LANE_F);
        st_o.c = lane_get(cdgh_i, LANE_C);
        st_o.d = lane_get(cdgh_i, LANE_D);
        st_o.g = lane_get(cdgh_i, LANE_G);
        st_o.h = lane_get(cdgh_i, LANE_H);
    end
endmodule

// File: rtl/sha512_dr_round.sv
module sha512_dr_round
    import sha512_dr_pkg::*;
(
    input  wstate_t st_i,
    input  word_t   wk_i,
    output wstate_t st_o
);
    word_t t_sum;
    word_t a_extra;

    // R6: shared temporary, then the two new words
    always_comb begin
        t_sum   = fn_ch(st_i.e, st_i.f, st_i.g) + big_sig1(st_i.e) + wk_i + st_i.h;
        a_extra = fn_maj(st_i.a, st_i.b, st_i.c) + big_sig0(st_i.a);
        st_o.a  = t_sum + a_extra;
        st_o.e  = t_sum + st_i.d;
        // R7: word shift
        st_o.b  = st_i.a;
        st_o.c  = st_i.b;
        st_o.d  = st_i.c;
        st_o.f  = st_i.e;
        st_o.g  = st_i.f;
        st_o.h  = st_i.g;
    end
endmodule

// File: rtl/sha512_dual_round.sv
module sha512_dual_round
    import sha512_dr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] abef_in,
    input  logic [VEC_W-1:0] cdgh_in,
    input  logic [WK_W-1:0]  wk_in,
    output logic             out_valid,
    output logic [VEC_W-1:0] abef_out
);
    typedef struct packed {
        logic vld;
        vec_t res;
    } reg_t;

    reg_t    st_d, st_q;
    wstate_t chain [ROUNDS+1];
    vec_t    packed_res;

    sha512_dr_unpack u_unpack (
        .abef_i (abef_in),
        .cdgh_i (cdgh_in),
        .st_o   (chain[0])
    );

    // R5: round r takes wk lane r
    for (genvar r = 0; r < ROUNDS; r++) begin : g_rnd
        sha512_dr_round u_round (
            .st_i (chain[r]),
            .wk_i (wk_in[r*WORD_W +: WORD_W]),
            .st_o (chain[r+1])
        );
    end

    // R8: repack final A, B, E, F
    always_comb begin
        packed_res = '0;
        packed_res[LANE_A*WORD_W +: WORD_W] = chain[ROUNDS].a;
        packed_res[LANE_B*WORD_W +: WORD_W] = chain[ROUNDS].b;
        packed_res[LANE_E*WORD_W +: WORD_W] = chain[ROUNDS].e;
        packed_res[LANE_F*WORD_W +: WORD_W] = chain[ROUNDS].f;
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = packed_res;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign abef_out  = st_q.res;

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R10
    idle_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(abef_out));

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && abef_out == '0));

endmodule

// File: tb/sha512_dual_round_bench.sv
module sha512_dual_round_bench;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [255:0] abef_in, cdgh_in;
    logic [127:0] wk_in;
    logic         out_valid;
    logic [255:0] abef_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sha512_dual_round u_sha512_dual_round (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .abef_in(abef_in), .cdgh_in(cdgh_in), .wk_in(wk_in),
        .out_valid(out_valid), .abef_out(abef_out)
    );

    // ---------------- reference model over an 8-word array ----------------
    // w[0..7] = A..H
    function automatic logic [63:0] rr(input logic [63:0] x, input int n);
        logic [127:0] dbl;
        dbl = {x, x} >> n;
        return dbl[63:0];
    endfunction

    function automatic logic [511:0] one_round(input logic [511:0] s, input logic [63:0] wk);
        logic [63:0] w [8];
        logic [63:0] s0, s1, mj, ch, t;
        for (int i = 0; i < 8; i++) w[i] = s[(7-i)*64 +: 64];
        s1 = rr(w[4],14) ^ rr(w[4],18) ^ rr(w[4],41);
        s0 = rr(w[0],28) ^ rr(w[0],34) ^ rr(w[0],39);
        mj = (w[0]&w[1]) | (w[2]&(w[0]|w[1]));
        ch = w[4] ? ((w[4]&w[5]) | (~w[4]&w[6])) : w[6];
        t  = ch + s1 + wk + w[7];
        for (int i = 7; i > 0; i--) w[i] = w[i-1];
        w[0] = t + mj + s0;
        w[4] = w[4] + t;  // w[4] now holds old D after the shift
        for (int i = 0; i < 8; i++) s[(7-i)*64 +: 64] = w[i];
        return s;
    endfunction

    function automatic logic [511:0] to_words(input logic [255:0] abef, input logic [255:0] cdgh);
        return {abef[255:192], abef[191:128], cdgh[255:192], cdgh[191:128],
                abef[127:64],  abef[63:0],    cdgh[127:64],  cdgh[63:0]};
    endfunction

    function automatic logic [255:0] abef_of(input logic [511:0] s);
        return {s[511:448], s[447:384], s[255:192], s[191:128]};
    endfunction

    function automatic logic [255:0] ref2(input logic [255:0] abef, input logic [255:0] cdgh,
                                          input logic [127:0] wk);
        logic [511:0] s;
        s = to_words(abef, cdgh);
        s = one_round(s, wk[63:0]);
        s = one_round(s, wk[127:64]);
        return abef_of(s);
    endfunction

    logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;
    function automatic logic [63:0] step(input logic [63:0] x);
        return {x[62:0], x[63] ^ x[62] ^ x[60] ^ x[59]} ^ (x * 64'd6364136223846793005);
    endfunction
    task automatic rnd64(output logic [63:0] v);
        lfsr = step(lfsr);
        v = lfsr;
    endtask

    // ---------------- check helpers ----------------
    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // drive at falling edge, result sampled just after next rising edge
    task automatic apply(input logic [255:0] a, input logic [255:0] c, input logic [127:0] wk);
        @(negedge clk);
        abef_in = a; cdgh_in = c; wk_in = wk; in_valid = 1'b1;
        @(posedge clk); #1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic apply_check(input string req, input logic [255:0] a,
                               input logic [255:0] c, input logic [127:0] wk);
        @(negedge clk);
        abef_in = a; cdgh_in = c; wk_in = wk; in_valid = 1'b1;
        @(posedge clk); #1;
        chk1({req, " valid"}, out_valid, 1'b1);
        chk(req, abef_out, ref2(a, c, wk));
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic rnd_vec(output logic [255:0] v);
        logic [63:0] w0, w1, w2, w3;
        rnd64(w0); rnd64(w1); rnd64(w2); rnd64(w3);
        v = {w3, w2, w1, w0};
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0;
        abef_in = '0; cdgh_in = '0; wk_in = '0;
        repeat (2) @(posedge clk);
        #1;
        chk1("R11 reset valid", out_valid, 1'b0);
        chk("R11 reset data", abef_out, '0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_single_words();
        // only A set: isolates sigma0 and majority on A (R1, R3)
        apply_check("R1", {64'h0123_4567_89AB_CDEF, 192'h0}, '0, '0);
        // only E set: isolates sigma1 and choice (R2, R3)
        apply_check("R2", {128'h0, 64'h8000_0000_0000_0001, 64'h0}, '0, '0);
        // only G and H set (R3 choice selects G when E is zero, H added)
        apply_check("R3", '0, {128'h0, 64'hFFFF_0000_FFFF_0000, 64'h1111}, '0);
    endtask

    task automatic t_lanes();
        // distinct marker in every lane (R4, R8)
        apply_check("R4", {64'h1, 64'h2, 64'h3, 64'h4}, {64'h5, 64'h6, 64'h7, 64'h8}, '0);
        apply_check("R8", {64'hA0, 64'hB0, 64'hE0, 64'hF0}, {64'hC0, 64'hD0, 64'h90, 64'h80},
                    {64'h0, 64'h0});
    endtask

    task automatic t_wk_order();
        // only one wk lane non-zero at a time (R5)
        apply_check("R5 lane0", '0, '0, {64'h0, 64'h0000_0000_DEAD_BEEF});
        apply_check("R5 lane1", '0, '0, {64'h0000_0000_DEAD_BEEF, 64'h0});
    endtask

    task automatic t_wrap();
        // all ones forces carries out of bit 63 (R6)
        apply_check("R6 wrap", {256{1'b1}}, {256{1'b1}}, {128{1'b1}});
        // new E = t + D only: zero A, B, C (R6, R7)
        apply_check("R7", {128'h0, 64'h7, 64'h9}, {64'h0, 64'hFFFF_FFFF_FFFF_FFF0, 64'h3, 64'h5},
                    {64'h11, 64'h22});
    endtask

    task automatic t_random();
        for (int k = 0; k < 40; k++) begin
            logic [255:0] a, c, w;
            rnd_vec(a); rnd_vec(c); rnd_vec(w);
            apply_check("R6 random", a, c, w[127:0]);
        end
    endtask

    task automatic t_hold();
        logic [255:0] a, c, w, exp;
        rnd_vec(a); rnd_vec(c); rnd_vec(w);
        exp = ref2(a, c, w[127:0]);
        apply(a, c, w[127:0]);
        for (int k = 0; k < 3; k++) begin
            logic [255:0] a2, c2;
            rnd_vec(a2); rnd_vec(c2);
            abef_in = a2; cdgh_in = c2; wk_in = ~w[127:0];
            @(posedge clk); #1;
            chk1("R10 idle valid", out_valid, 1'b0);
            chk("R10 hold", abef_out, exp);
            @(negedge clk);
        end
    endtask

    task automatic t_chain();
        logic [511:0] s;
        logic [255:0] cur, prev;
        rnd_vec(cur); rnd_vec(prev);
        s = to_words(cur, prev);
        for (int k = 0; k < 8; k++) begin
            logic [255:0] w;
            rnd_vec(w);
            @(negedge clk);
            abef_in = cur; cdgh_in = prev; wk_in = w[127:0]; in_valid = 1'b1;
            @(posedge clk); #1;
            s = one_round(s, w[63:0]);
            s = one_round(s, w[127:64]);
            chk("R12 chain", abef_out, abef_of(s));
            prev = cur;
            cur  = abef_out;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset_mid();
        logic [255:0] a;
        rnd_vec(a);
        apply(a, ~a, a[127:0]);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1;
        chk1("R11 mid valid", out_valid, 1'b0);
        chk("R11 mid data", abef_out, '0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        t_reset();
        t_single_words();
        t_lanes();
        t_wk_order();
        t_wrap();
        t_random();
        t_hold();
        t_chain();
        t_reset_mid();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule